// File: doc/BRIEF.md
# Timer/Counter Pin Allocator

This block decides which general-purpose I/O lines are handed to the timer and counter functions of a device. Up to four timers and two counters can be switched on, and each one that is switched on claims one line of a bank of sixteen. The lines are claimed one after another, starting at a programmable base line. The claim order is fixed and has no gaps.

A configuration word holds the number of active timers, one enable for each counter, the base line and a flag that marks a divided timer clock base. The word is applied on a one-cycle load strobe. The block then publishes a 3-bit owner code for each line, a sticky direction-override bit for each line, and an error flag. An illegal word is refused and the previous map stays in place. Counter 0 cannot run from a divided clock base, so that combination is refused.

Top module: `tcPinAlloc`

## Requirements
- R1: After reset every owner code is 0, every direction-override bit is 0 and the error flag is 0.
- R2: Owner codes are 3 bits; line k uses bits [3k+2:3k] of `ownerCode`. Code 0 is plain I/O, codes 1 to 4 are timers 0 to 3, code 5 is counter 0 and code 6 is counter 1. Functions are claimed in that order: timers ascending, then counter 0, then counter 1.
- R3: The first enabled function sits on the line whose index equals `pinOffset`. Each further enabled function sits on the next line. A disabled function leaves no gap.
- R4: Every offset from 0 to 8 is accepted with all six functions on. At offset 8 the highest claimed line is 13.
- R5: A load with `pinOffset` above 8, or with `timerCount` above 4, sets the error flag and leaves owner codes and override bits unchanged.
- R6: A load with counter 0 enabled while `divBase` is 1 sets the error flag and keeps the old map. With `divBase` at 1 and counter 0 off, the load is legal, and counter 1 packs directly after the timers.
- R7: A line's direction-override bit is set once the line has been claimed. It stays set after later loads release the line, and only reset clears it.
- R8: Every line that the current map does not claim reports code 0.
- R9: Outputs change only on the clock edge that samples `loadStrobe` high, and are visible from the following cycle. Input changes without the strobe have no effect.
- R10: A legal load clears an earlier error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStrobe | input | 1 | Apply the configuration on this edge |
| timerCount | input | 3 | Number of active timers (legal 0 to 4) |
| cnt0En | input | 1 | Counter 0 enable |
| cnt1En | input | 1 | Counter 1 enable |
| pinOffset | input | 4 | First line to claim (legal 0 to 8) |
| divBase | input | 1 | Divided timer clock base selected |
| ownerCode | output | 48 | Per-line 3-bit owner code |
| dirOverride | output | 16 | Per-line sticky direction override |
| cfgError | output | 1 | Last load was refused |

## Verification
The bench targets packing across gaps. Timer 0 with only counter 1 must land on adjacent lines. A design that reserved a slot for each disabled function would leave a hole. It also sweeps every offset with all six functions on, so a design with an off-by-one range check would refuse offset 8 or accept offset 9. Refused loads, both out-of-range and counter 0 on a divided base, are followed by a map comparison. A design that committed before checking would move lines. Override bits are compared after functions are switched off, which catches a design that recomputes direction from the live map.

// File: rtl/tcPinAlloc_pkg.sv
package tcPinAlloc_pkg;
  localparam int OWN_W = 3;
  localparam int NUM_FUNCS = 6;
  typedef logic [OWN_W-1:0] ownerCode_t;
  localparam ownerCode_t OWN_PLAIN = 3'd0;
  localparam ownerCode_t OWN_CNT0 = 3'd5;
  localparam ownerCode_t OWN_CNT1 = 3'd6;

  typedef struct packed {
    logic commit;
    logic setErr;
    logic clrErr;
  } ctrlStrobes_t;
endpackage

// File: rtl/tcPinAlloc_ctrl.sv
module tcPinAlloc_ctrl
  import tcPinAlloc_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int MAX_OFFSET = 8,
  localparam int TC_W = $clog2(NUM_TIMERS + 1),
  localparam int OFF_W = 4
) (
  input  logic             loadStrobe,
  input  logic [TC_W-1:0]  timerCount,
  input  logic             cnt0En,
  input  logic [OFF_W-1:0] pinOffset,
  input  logic             divBase,
  output ctrlStrobes_t     strobes
);
  logic badRange;
  logic badClock;

  always_comb begin
    badRange = (int'(pinOffset) > MAX_OFFSET) || (int'(timerCount) > NUM_TIMERS);
    badClock = cnt0En && divBase;
    strobes.commit = loadStrobe && !badRange && !badClock;
    strobes.setErr = loadStrobe && (badRange || badClock);
    strobes.clrErr = loadStrobe && !badRange && !badClock;
  end
endmodule

// File: rtl/tcPinAlloc_datapath.sv
module tcPinAlloc_datapath
  import tcPinAlloc_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_TIMERS = 4,
  localparam int TC_W = $clog2(NUM_TIMERS + 1),
  localparam int OFF_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [TC_W-1:0]            timerCount,
  input  logic                       cnt0En,
  input  logic                       cnt1En,
  input  logic [OFF_W-1:0]           pinOffset,
  output logic [NUM_LINES*OWN_W-1:0] ownerCode,
  output logic [NUM_LINES-1:0]       dirOverride,
  output logic                       cfgError
);
  ownerCode_t nextOwner [NUM_LINES];
  ownerCode_t ownerQ [NUM_LINES];
  logic [NUM_LINES-1:0] claimMask;
  logic errQ;

  always_comb begin
    int unsigned pos;
    logic en;
    pos = int'(pinOffset);
    claimMask = '0;
    for (int l = 0; l < NUM_LINES; l++) nextOwner[l] = OWN_PLAIN;
    for (int f = 0; f < NUM_TIMERS + 2; f++) begin
      if (f < NUM_TIMERS) en = (f < int'(timerCount));
      else if (f == NUM_TIMERS) en = cnt0En;
      else en = cnt1En;
      if (en && pos < NUM_LINES) begin
        nextOwner[pos] = ownerCode_t'(f + 1);
        claimMask[pos] = 1'b1;
        pos = pos + 1;
      end
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ownerQ[l] <= OWN_PLAIN;
        dirOverride[l] <= 1'b0;
      end else if (strobes.commit) begin
        ownerQ[l] <= nextOwner[l];
        dirOverride[l] <= dirOverride[l] | claimMask[l];
      end
    end
    assign ownerCode[l*OWN_W +: OWN_W] = ownerQ[l];
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else if (strobes.setErr) errQ <= 1'b1;
    else if (strobes.clrErr) errQ <= 1'b0;
  end
  assign cfgError = errQ;
endmodule

// File: rtl/tcPinAlloc.sv
module tcPinAlloc
  import tcPinAlloc_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_TIMERS = 4,
  parameter int MAX_OFFSET = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadStrobe,
  input  logic [2:0]            timerCount,
  input  logic                  cnt0En,
  input  logic                  cnt1En,
  input  logic [3:0]            pinOffset,
  input  logic                  divBase,
  output logic [NUM_LINES*3-1:0] ownerCode,
  output logic [NUM_LINES-1:0]  dirOverride,
  output logic                  cfgError
);
  ctrlStrobes_t strobes;

  tcPinAlloc_ctrl #(.NUM_TIMERS(NUM_TIMERS), .MAX_OFFSET(MAX_OFFSET)) ctrl (
    .loadStrobe(loadStrobe), .timerCount(timerCount), .cnt0En(cnt0En),
    .pinOffset(pinOffset), .divBase(divBase), .strobes(strobes));

  tcPinAlloc_datapath #(.NUM_LINES(NUM_LINES), .NUM_TIMERS(NUM_TIMERS)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .timerCount(timerCount),
    .cnt0En(cnt0En), .cnt1En(cnt1En), .pinOffset(pinOffset),
    .ownerCode(ownerCode), .dirOverride(dirOverride), .cfgError(cfgError));
endmodule

// File: rtl/tcPinAlloc_chk.sv
module tcPinAlloc_chk #(
  parameter int NUM_LINES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   loadStrobe,
  input logic [2:0]             timerCount,
  input logic                   cnt0En,
  input logic [3:0]             pinOffset,
  input logic                   divBase,
  input logic [NUM_LINES*3-1:0] ownerCode,
  input logic [NUM_LINES-1:0]   dirOverride,
  input logic                   cfgError
);
  logic badLoad;
  logic [NUM_LINES-1:0] ownedMask;
  int dupCount;

  always_comb begin
    badLoad = loadStrobe && ((pinOffset > 4'd8) || (timerCount > 3'd4) || (cnt0En && divBase));
    ownedMask = '0;
    dupCount = 0;
    for (int l = 0; l < NUM_LINES; l++) ownedMask[l] = (ownerCode[l*3 +: 3] != 3'd0);
    for (int c = 1; c <= 6; c++) begin
      int n;
      n = 0;
      for (int l = 0; l < NUM_LINES; l++) if (ownerCode[l*3 +: 3] == 3'(c)) n++;
      if (n > 1) dupCount++;
    end
  end

  assert_no_move_without_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |=> $stable(ownerCode) && $stable(dirOverride));
  assert_override_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dirOverride & $past(dirOverride)) == $past(dirOverride)));
  assert_bad_load_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    badLoad |=> cfgError);
  assert_bad_load_keeps_map_R6: assert property (@(posedge clk) disable iff (!rstN)
    badLoad |=> $stable(ownerCode));
  assert_owned_has_override_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ownedMask & ~dirOverride) == '0);
  assert_unique_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
    dupCount == 0);
endmodule

bind tcPinAlloc tcPinAlloc_chk #(.NUM_LINES(NUM_LINES)) chk (
  .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .timerCount(timerCount),
  .cnt0En(cnt0En), .pinOffset(pinOffset), .divBase(divBase),
  .ownerCode(ownerCode), .dirOverride(dirOverride), .cfgError(cfgError));

// File: tb/tcPinAlloc_test.sv
module tcPinAlloc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadStrobe = 1'b0;
  logic [2:0] timerCount = '0;
  logic cnt0En = 1'b0, cnt1En = 1'b0, divBase = 1'b0;
  logic [3:0] pinOffset = '0;
  logic [NL*3-1:0] ownerCode;
  logic [NL-1:0] dirOverride;
  logic cfgError;

  int checks = 0;
  int failures = 0;
  int refOwner [NL];
  bit refDir [NL];
  bit refErr = 1'b0;

  tcPinAlloc uut (.clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .timerCount(timerCount),
    .cnt0En(cnt0En), .cnt1En(cnt1En), .pinOffset(pinOffset), .divBase(divBase),
    .ownerCode(ownerCode), .dirOverride(dirOverride), .cfgError(cfgError));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic modelLoad(int tc, bit c0, bit c1, int off, bit dv);
    int pos;
    int fn [$];
    if (off > 8 || tc > 4 || (c0 && dv)) begin
      refErr = 1'b1;
      return;
    end
    refErr = 1'b0;
    for (int t = 0; t < tc; t++) fn.push_back(t + 1);
    if (c0) fn.push_back(5);
    if (c1) fn.push_back(6);
    for (int l = 0; l < NL; l++) refOwner[l] = 0;
    pos = off;
    foreach (fn[i]) begin
      refOwner[pos] = fn[i];
      refDir[pos] = 1'b1;
      pos++;
    end
  endtask

  task automatic checkAll(string req);
    int bad;
    bad = 0;
    for (int l = 0; l < NL; l++) begin
      if (int'(ownerCode[l*3 +: 3]) != refOwner[l] || dirOverride[l] != refDir[l]) begin
        bad = 1;
        $display("FAIL %s line %0d: actual owner=%0d dir=%0b expected owner=%0d dir=%0b",
                 req, l, ownerCode[l*3 +: 3], dirOverride[l], refOwner[l], refDir[l]);
      end
    end
    if (cfgError != refErr) begin
      bad = 1;
      $display("FAIL %s error flag: actual=%0b expected=%0b", req, cfgError, refErr);
    end
    checks++;
    if (bad) failures++;
  endtask

  task automatic doLoad(int tc, bit c0, bit c1, int off, bit dv, string req);
    @(negedge clk);
    timerCount = 3'(tc); cnt0En = c0; cnt1En = c1; pinOffset = 4'(off); divBase = dv;
    loadStrobe = 1'b1;
    @(posedge clk);
    modelLoad(tc, c0, c1, off, dv);
    @(negedge clk);
    loadStrobe = 1'b0;
    checkAll(req);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin refOwner[l] = 0; refDir[l] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");
    // R2/R3: one timer plus counter 1, no gap where counter 0 would be
    doLoad(1, 0, 1, 0, 0, "R3 gapless pack");
    doLoad(4, 1, 1, 0, 0, "R2 full order");
    doLoad(2, 1, 1, 8, 0, "R2 order offset8");
    // R4: all offsets with everything on
    for (int o = 0; o <= 8; o++) doLoad(4, 1, 1, o, 0, "R4 offset sweep");
    // R7: disable all; overrides remain
    doLoad(0, 0, 0, 3, 0, "R7 sticky override");
    doLoad(0, 0, 1, 5, 0, "R8 single counter");
    // R5: out-of-range loads keep map
    doLoad(4, 1, 1, 9, 0, "R5 offset 9");
    doLoad(5, 0, 0, 2, 0, "R5 timers 5");
    doLoad(3, 0, 1, 15, 0, "R5 offset 15");
    // R10: legal load clears error
    doLoad(3, 0, 1, 2, 0, "R10 error clear");
    // R6: counter 0 on divided base refused; divided base without it fine
    doLoad(4, 1, 1, 1, 1, "R6 cnt0 on div base");
    doLoad(4, 0, 1, 1, 1, "R6 div base no cnt0");
    // R9: changes without strobe have no effect
    @(negedge clk);
    timerCount = 3'd0; cnt0En = 1'b1; pinOffset = 4'd7;
    repeat (4) @(negedge clk);
    checkAll("R9 no strobe");
    // R1 again: reset clears sticky overrides
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int l = 0; l < NL; l++) begin refOwner[l] = 0; refDir[l] = 1'b0; end
    refErr = 1'b0;
    @(negedge clk);
    checkAll("R1 second reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule